// File: doc/BRIEF.md
# Banked Register Map Access Controller

This block is the register file that sits behind a byte-oriented serial control bus. A bit-level protocol engine, outside this block, turns line activity into single-cycle events: a transaction start, a byte written by the host, a request for a byte to be read, and a transaction stop. The block uses these events to manage an 8-bit address pointer and to move bytes into and out of register storage.

The first byte the host writes after a start sets the pointer, which software cannot read back. Each later data byte, written or read, uses the register the pointer selects, and the pointer then moves to the next address. The lower 64 addresses form one shared page. A select bit in a shared register decides which of two banks serves addresses 0x40 and above. The primary bank covers that whole range. The secondary bank holds only 0x40 to 0x9C. In secondary mode, an address above 0x9C reads as zero and takes no writes.

Top module: `regmap_access_ctrl`

## Requirements
- R1: After synchronous reset every stored register is 0x00, the pointer is 0x00 and `rd_valid` is low.
- R2: The first `bus_wr` byte after `bus_start` loads the pointer and writes no register.
- R3: Each later `bus_wr` byte in the same transaction is stored at the pointer address, and the pointer then increments by one.
- R4: A `bus_rd` pulse puts the byte at the pointer address on `rd_data` and raises `rd_valid` for one cycle on the next clock edge. The pointer then increments by one.
- R5: Addresses 0x00 to 0x3F reach the same shared storage whatever the select bit holds.
- R6: Bit 5 of shared register 0x0E is the select bit. When it is 0, addresses 0x40 to 0xFF use the primary bank. When it is 1, they use the secondary bank. The two banks keep separate contents.
- R7: With the select bit at 1, addresses 0x9D to 0xFF read as 0x00 and ignore writes. The primary bank's contents at those addresses stay unchanged.
- R8: Incrementing the pointer from 0xFF gives 0x00.
- R9: `bus_stop` leaves the pointer unchanged. A read transaction that writes no new address continues from the current pointer.
- R10: A change to the select bit applies to the first register access after the write that changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Transaction start event (one cycle) |
| bus_stop | input | 1 | Transaction stop event (one cycle) |
| bus_wr | input | 1 | Host-written byte event (one cycle) |
| bus_rd | input | 1 | Host read request event (one cycle) |
| bus_wdata | input | 8 | Byte carried by `bus_wr` |
| rd_data | output | 8 | Byte returned for the latest read request |
| rd_valid | output | 1 | High for one cycle when `rd_data` is new |

## Verification
The hardest state to reach from the ports is a secondary-bank access above 0x9C. To get there, the bench first sets the select bit through a write to the shared page. It then places the pointer at 0x9C and lets a single write burst carry it across the end of the secondary bank. The primary bank is filled at the same address beforehand. Clearing the select bit afterwards shows whether that bank's content survived. The pointer wrap at 0xFF is reached the same way: a burst that starts at 0xFF and spills into shared address 0x00.

// File: rtl/regmap_pkg.sv
package regmap_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int MAP_SPLIT = 64;
    localparam int SUB_LAST  = 8'h9C;
    localparam int SEL_ADDR  = 8'h0E;
    localparam int SEL_BIT   = 5;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic [1:0] {
        TGT_SHARED  = 2'd0,
        TGT_PRIMARY = 2'd1,
        TGT_SECOND  = 2'd2,
        TGT_NONE    = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e  tgt;
        addr_t idx;
    } route_t;

    typedef struct packed {
        logic  start;
        logic  stop;
        logic  wr;
        logic  rd;
        data_t data;
    } bus_ev_t;

    function automatic route_t route_addr(input addr_t a, input logic alt);
        route_t r;
        if (int'(a) < MAP_SPLIT) begin
            r.tgt = TGT_SHARED;
            r.idx = a;
        end else if (!alt) begin
            r.tgt = TGT_PRIMARY;
            r.idx = addr_t'(int'(a) - MAP_SPLIT);
        end else if (int'(a) <= SUB_LAST) begin
            r.tgt = TGT_SECOND;
            r.idx = addr_t'(int'(a) - MAP_SPLIT);
        end else begin
            r.tgt = TGT_NONE;
            r.idx = '0;
        end
        return r;
    endfunction

endpackage

// File: rtl/subaddr_ptr.sv
module subaddr_ptr
    import regmap_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    output addr_t   ptr,
    output logic    wr_go,
    output logic    rd_go
);

    logic  expect_addr;
    addr_t ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q       <= '0;
            expect_addr <= 1'b1;
        end else if (ev.start) begin
            expect_addr <= 1'b1;
        end else if (ev.wr) begin
            if (expect_addr) begin
                ptr_q       <= ev.data;
                expect_addr <= 1'b0;
            end else begin
                ptr_q <= ptr_q + 1'b1;
            end
        end else if (ev.rd) begin
            ptr_q       <= ptr_q + 1'b1;
            expect_addr <= 1'b0;
        end
    end

    assign ptr   = ptr_q;
    assign wr_go = ev.wr && !ev.start && !expect_addr;
    assign rd_go = ev.rd && !ev.start && !ev.wr;

    // R2
    addr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.wr && !ev.start && expect_addr) |=> (ptr_q == $past(ev.data)));

    // R3 R4 R8
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_go || rd_go) |=> (ptr_q == addr_t'($past(ptr_q) + 1'b1)));

    // R9
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && !ev.wr && !ev.rd) |=> $stable(ptr_q));

endmodule

// File: rtl/reg_bank.sv
module reg_bank
    import regmap_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  data_t         wdata,
    output data_t         rdata
);

    data_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we && (int'(idx) < DEPTH)) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = (int'(idx) < DEPTH) ? mem[idx] : '0;

    // R3
    write_range_chk: assert property (@(posedge clk) disable iff (rst)
        we |-> (int'(idx) < DEPTH));

    // R3
    write_store_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/regmap_access_ctrl.sv
module regmap_access_ctrl
    import regmap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] rd_data,
    output logic       rd_valid
);

    localparam int N_SHARED  = MAP_SPLIT;
    localparam int N_PRIMARY = (1 << ADDR_W) - MAP_SPLIT;
    localparam int N_SECOND  = SUB_LAST - MAP_SPLIT + 1;
    localparam int SW = $clog2(N_SHARED);
    localparam int PW = $clog2(N_PRIMARY);
    localparam int XW = $clog2(N_SECOND);

    bus_ev_t ev;
    addr_t   ptr;
    logic    wr_go, rd_go;
    logic    sel_q;
    route_t  rt;
    logic    we_s, we_p, we_x;
    data_t   rd_s, rd_p, rd_x, rd_mux;
    data_t   rd_data_q;
    logic    rd_valid_q;

    assign ev = '{start: bus_start, stop: bus_stop, wr: bus_wr, rd: bus_rd, data: bus_wdata};

    subaddr_ptr u_ptr (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .ptr   (ptr),
        .wr_go (wr_go),
        .rd_go (rd_go)
    );

    assign rt   = route_addr(ptr, sel_q);
    assign we_s = wr_go && (rt.tgt == TGT_SHARED);
    assign we_p = wr_go && (rt.tgt == TGT_PRIMARY);
    assign we_x = wr_go && (rt.tgt == TGT_SECOND);

    reg_bank #(.DEPTH(N_SHARED)) u_shared (
        .clk (clk), .rst (rst), .we (we_s),
        .idx (rt.idx[SW-1:0]), .wdata (ev.data), .rdata (rd_s)
    );

    reg_bank #(.DEPTH(N_PRIMARY)) u_primary (
        .clk (clk), .rst (rst), .we (we_p),
        .idx (rt.idx[PW-1:0]), .wdata (ev.data), .rdata (rd_p)
    );

    reg_bank #(.DEPTH(N_SECOND)) u_second (
        .clk (clk), .rst (rst), .we (we_x),
        .idx (rt.idx[XW-1:0]), .wdata (ev.data), .rdata (rd_x)
    );

    // shadow of the map-select bit, kept beside the decode so the
    // route never waits on a read of the shared bank
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
        end else if (we_s && (ptr == addr_t'(SEL_ADDR))) begin
            sel_q <= ev.data[SEL_BIT];
        end
    end

    always_comb begin
        unique case (rt.tgt)
            TGT_SHARED:  rd_mux = rd_s;
            TGT_PRIMARY: rd_mux = rd_p;
            TGT_SECOND:  rd_mux = rd_x;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= rd_go;
            if (rd_go) begin
                rd_data_q <= rd_mux;
            end
        end
    end

    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;

    // R4
    rd_valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(bus_rd));

    // R5
    low_page_shared_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_go && (int'(ptr) < MAP_SPLIT)) |-> (we_s && !we_p && !we_x));

    // R6
    one_bank_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({we_s, we_p, we_x}));

    // R7
    hole_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_go && sel_q && (int'(ptr) > SUB_LAST)) |=> (rd_data == '0));

    // R10
    sel_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (we_s && (ptr == addr_t'(SEL_ADDR))) |=> (sel_q == $past(bus_wdata[SEL_BIT])));

endmodule

// File: tb/regmap_access_ctrl_test.sv
module regmap_access_ctrl_test;

    localparam logic [1:0] OP_S = 2'd0;
    localparam logic [1:0] OP_P = 2'd1;
    localparam logic [1:0] OP_W = 2'd2;
    localparam logic [1:0] OP_R = 2'd3;
    localparam int NV = 54;

    // entry: op, byte (write data or expected read data), requirement tag
    localparam logic [13:0] VEC [NV] = '{
        {OP_S, 8'h00, 4'd0}, {OP_W, 8'h10, 4'd2}, {OP_W, 8'hA1, 4'd3}, {OP_W, 8'hA2, 4'd3},
        {OP_P, 8'h00, 4'd0}, {OP_S, 8'h00, 4'd0}, {OP_W, 8'h10, 4'd2}, {OP_P, 8'h00, 4'd0},
        {OP_S, 8'h00, 4'd0}, {OP_R, 8'hA1, 4'd4}, {OP_R, 8'hA2, 4'd4}, {OP_P, 8'h00, 4'd0},
        {OP_S, 8'h00, 4'd0}, {OP_W, 8'h40, 4'd0}, {OP_W, 8'h55, 4'd6}, {OP_W, 8'h66, 4'd6},
        {OP_P, 8'h00, 4'd0}, {OP_S, 8'h00, 4'd0}, {OP_W, 8'h0E, 4'd0}, {OP_W, 8'h20, 4'd10},
        {OP_P, 8'h00, 4'd0}, {OP_S, 8'h00, 4'd0}, {OP_W, 8'h40, 4'd0}, {OP_P, 8'h00, 4'd0},
        {OP_S, 8'h00, 4'd0}, {OP_R, 8'h00, 4'd10}, {OP_P, 8'h00, 4'd0}, {OP_S, 8'h00, 4'd0},
        {OP_W, 8'h40, 4'd0}, {OP_W, 8'h77, 4'd6}, {OP_P, 8'h00, 4'd0}, {OP_S, 8'h00, 4'd0},
        {OP_W, 8'h40, 4'd0}, {OP_P, 8'h00, 4'd0}, {OP_S, 8'h00, 4'd0}, {OP_R, 8'h77, 4'd6},
        {OP_P, 8'h00, 4'd0}, {OP_S, 8'h00, 4'd0}, {OP_W, 8'h10, 4'd0}, {OP_P, 8'h00, 4'd0},
        {OP_S, 8'h00, 4'd0}, {OP_R, 8'hA1, 4'd5}, {OP_P, 8'h00, 4'd0}, {OP_S, 8'h00, 4'd0},
        {OP_W, 8'h0E, 4'd0}, {OP_W, 8'h00, 4'd6}, {OP_P, 8'h00, 4'd0}, {OP_S, 8'h00, 4'd0},
        {OP_W, 8'h40, 4'd0}, {OP_P, 8'h00, 4'd0}, {OP_S, 8'h00, 4'd0}, {OP_R, 8'h55, 4'd6},
        {OP_R, 8'h66, 4'd6}, {OP_P, 8'h00, 4'd0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_start = 1'b0, bus_stop = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] rd_data;
    logic       rd_valid;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    regmap_access_ctrl uut (
        .clk (clk), .rst (rst),
        .bus_start (bus_start), .bus_stop (bus_stop),
        .bus_wr (bus_wr), .bus_rd (bus_rd),
        .bus_wdata (bus_wdata),
        .rd_data (rd_data), .rd_valid (rd_valid)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic ev_start();
        @(negedge clk); bus_start = 1'b1;
        @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic ev_stop();
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic ev_write(input logic [7:0] b);
        @(negedge clk); bus_wr = 1'b1; bus_wdata = b;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    // returns the byte presented one edge after the request
    task automatic ev_read(input string req, input logic [7:0] exp);
        @(negedge clk); bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
        check({req, " rd_valid"}, {7'd0, rd_valid}, 8'h01);
        check(req, rd_data, exp);
    endtask

    task automatic set_ptr(input logic [7:0] a);
        ev_start(); ev_write(a); ev_stop();
    endtask

    task automatic read_at(input string req, input logic [7:0] a, input logic [7:0] exp);
        set_ptr(a);
        ev_start(); ev_read(req, exp); ev_stop();
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state seen at the ports
        check("R1 rd_valid in reset", {7'd0, rd_valid}, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rd_valid after reset", {7'd0, rd_valid}, 8'h00);
        ev_start(); ev_read("R1 pointer 00 reg 00", 8'h00); ev_stop();

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            logic [7:0] b;
            logic [3:0] tag;
            {op, b, tag} = VEC[i];
            case (op)
                OP_S: ev_start();
                OP_P: ev_stop();
                OP_W: ev_write(b);
                default: ev_read($sformatf("R%0d vector %0d", tag, i), b);
            endcase
        end

        // R2: the address byte itself must not land in the old target
        set_ptr(8'h30);
        set_ptr(8'h31);
        read_at("R2 address byte not stored", 8'h30, 8'h00);

        // R7: fill primary 0x9D, then cross the end of the secondary bank
        ev_start(); ev_write(8'h9D); ev_write(8'h12); ev_stop();
        ev_start(); ev_write(8'h0E); ev_write(8'h20); ev_stop();
        ev_start(); ev_write(8'h9C); ev_write(8'h3C); ev_write(8'h99); ev_stop();
        read_at("R7 secondary last reg", 8'h9C, 8'h3C);
        read_at("R7 secondary hole reads zero", 8'h9D, 8'h00);
        read_at("R7 secondary hole high", 8'hFF, 8'h00);
        ev_start(); ev_write(8'h0E); ev_write(8'h00); ev_stop();
        read_at("R7 primary 9D untouched", 8'h9D, 8'h12);
        read_at("R6 select readback", 8'h0E, 8'h00);

        // R8: burst from 0xFF wraps into shared 0x00
        ev_start(); ev_write(8'hFF); ev_write(8'hEE); ev_write(8'hCC); ev_stop();
        set_ptr(8'hFF);
        ev_start(); ev_read("R8 reg FF", 8'hEE); ev_read("R8 wrapped to 00", 8'hCC); ev_stop();

        // R9: stop keeps the pointer between read transactions
        ev_start(); ev_write(8'h20); ev_write(8'h5A); ev_write(8'h5B); ev_stop();
        set_ptr(8'h20);
        ev_start(); ev_read("R9 first read", 8'h5A); ev_stop();
        ev_start(); ev_read("R9 continues after stop", 8'h5B); ev_stop();

        // R1: reset mid-run clears storage
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        read_at("R1 storage cleared", 8'h10, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule